// File: doc/BRIEF.md
# Multi-Queue Inter-Processor Mailbox

The block lets several processors exchange 32-bit words through a small register port. It holds six independent first-in first-out queues of message words. A write to a queue's message register pushes a word into that queue, and a read from the same register pops the oldest word. Each queue also has a register that says whether it is full and a register that gives how many words it holds.

Each queue produces two events. A new-message event fires on every accepted push. A not-full event fires when a pop takes a full queue back to having room. Four interrupt users each have their own pending register and mask register. The two events of every queue sit side by side in those registers, so any user can follow the sending end, the receiving end, or both ends of any queue. Pending bits are cleared by writing ones. Each user has its own interrupt line, which is high whenever a pending bit is also unmasked.

A fixed identification word, a configuration register with two idle-hint bits and a reset-complete flag complete the register set. The register port is a single-cycle strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: Words written to the message register of queue n (byte offset 0x40 + 4n) are returned in the same order by successive reads of that register. A read removes the word it returns.
- R2: Each queue holds 4 words. Its count register (0xC0 + 4n) reads the number of words held, from 0 to 4. Its full register (0x80 + 4n) reads 1 when 4 words are held and 0 otherwise.
- R3: A write to a full queue is discarded. The count stays at 4, and the words read afterwards are the four accepted ones.
- R4: A read of an empty queue's message register returns 0 and leaves the queue unchanged. The next word pushed is the next word popped.
- R5: Every accepted push into queue n sets bit 2n of every user's pending register. User u's pending register is at 0x100 + 8u.
- R6: A pop from a full queue n sets bit 2n+1 of every user's pending register. Pops from a queue that is not full do not set that bit.
- R7: Writing to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a bit is set by an event and cleared by a write in the same cycle, it stays set.
- R8: User u's mask register (0x104 + 8u) reads back what was written to its low 12 bits. The user's interrupt output is high exactly when its pending register AND its mask register is non-zero.
- R9: After reset, all queues are empty and every pending and mask register reads 0. The configuration register reads 0, all interrupt outputs are low, and the reset-status register (0x14) reads 1 in bit 0.
- R10: The identification register (0x00) reads 0x00000020. Of the configuration register (0x10), only bits 0 and 4 are stored; its other bits read 0.
- R11: A read of any offset that is not a defined register, including offsets that are not word-aligned, returns 0. A write to such an offset, or to the identification or reset-status register, changes nothing.
- R12: Read data is valid in the cycle after the read strobe and reads 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 12 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; pops when aimed at a message register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| irq | output | 4 | One interrupt line per user |

## Verification
The properties assume that a read strobe and a write strobe never arrive in the same cycle. This is what lets a push change a queue's count by exactly one and lets an idle full or empty queue keep its count. The properties also assume that the strobes are low while reset is held. The stimulus applies every access as a one-cycle strobe that starts at a falling clock edge. It raises at most one strobe per access and never drives a strobe during reset. Within those limits, it sweeps every queue through fill, overflow, drain and underflow, and it sweeps every mask bit of every user.

// File: rtl/ipc_mbox_pkg.sv
// Package ipc_mbox_pkg
// Shared constants of the mailbox: word indices of each register window
// (byte offset divided by four) and the fixed identification value.
// Assumes a word-addressed decode in which the low two address bits are zero.
package ipc_mbox_pkg;
    localparam int ID_W     = 0;    // identification word
    localparam int CFG_W    = 4;    // configuration word
    localparam int RSTAT_W  = 5;    // reset-status word
    localparam int MSG_W    = 16;   // first message word (0x40)
    localparam int FULL_W   = 32;   // first full-flag word (0x80)
    localparam int CNT_W    = 48;   // first count word (0xC0)
    localparam int IRQ_W    = 64;   // first pending word (0x100), mask at +1
    localparam int WIN_MAX  = 16;   // queues that fit in one window
    localparam logic [31:0] ID_VALUE = 32'h0000_0020;
endpackage

// File: rtl/mbox_queue.sv
// Module mbox_queue
// One message queue: a circular store of DEPTH words with read/write
// pointers and an occupancy counter. It accepts a push only when not full
// and a pop only when not empty, and it reports which of those happened.
// Assumes DEPTH >= 2. The head output reads zero while the queue is empty.
module mbox_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          newmsg,
    output logic          notfull
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = (count != '0) ? store[rptr] : '0;
    assign newmsg  = do_push;
    assign notfull = do_pop && full;

    // Write an accepted word into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= din;
    end

    // Advance the pointers and the occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/mbox_irq_user.sv
// Module mbox_irq_user
// Pending and mask registers of one interrupt user. Event pulses set
// pending bits. A pending write clears the bits written as one, and an event
// in the same cycle wins over the clear. The interrupt is the OR of
// pending AND mask. Assumes the pulses last one cycle per event.
module mbox_irq_user #(
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set_ev,
    input  logic          pend_wr,
    input  logic          mask_wr,
    input  logic [EW-1:0] wbits,
    output logic [EW-1:0] pending,
    output logic [EW-1:0] mask,
    output logic          irq
);
    assign irq = |(pending & mask);

    // Pending bits: clear the bits written as one, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~(pend_wr ? wbits : '0)) | set_ev;
    end

    // Mask register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wbits;
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Module ipc_mailbox
// Top of the mailbox. It decodes the single-cycle register port, places the
// queues and the interrupt users, and registers the read data. The two
// events of queue n go to pending bits 2n and 2n+1 of every user.
// Assumes NUM_Q <= 16 and NUM_U <= 32 so that each register window fits.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_Q = 6,
    parameter int NUM_U = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [NUM_U-1:0] irq
);
    localparam int EW = 2 * NUM_Q;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int WW = AW - 2;

    logic [WW-1:0]                widx;
    logic                         aligned;
    logic [NUM_Q-1:0][DW-1:0]     q_head;
    logic [NUM_Q-1:0][CW-1:0]     q_cnt;
    logic [NUM_Q-1:0]             q_full;
    logic [EW-1:0]                ev;
    logic [NUM_U-1:0][EW-1:0]     st_all;
    logic [NUM_U-1:0][EW-1:0]     en_all;
    logic                         cfg_auto, cfg_smart;
    logic [DW-1:0]                rd_mux;

    assign widx    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        logic hit;
        assign hit = aligned && (int'(widx) == MSG_W + q);
        mbox_queue #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (wr_en && hit),
            .pop     (rd_en && hit),
            .din     (wdata),
            .head    (q_head[q]),
            .count   (q_cnt[q]),
            .full    (q_full[q]),
            .newmsg  (ev[2*q]),
            .notfull (ev[2*q+1])
        );
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_user
        logic pend_hit, mask_hit;
        assign pend_hit = aligned && (int'(widx) == IRQ_W + 2*u);
        assign mask_hit = aligned && (int'(widx) == IRQ_W + 2*u + 1);
        mbox_irq_user #(.EW(EW)) u_user (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_ev  (ev),
            .pend_wr (wr_en && pend_hit),
            .mask_wr (wr_en && mask_hit),
            .wbits   (wdata[EW-1:0]),
            .pending (st_all[u]),
            .mask    (en_all[u]),
            .irq     (irq[u])
        );
    end

    // Configuration register: only the two idle-hint bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_auto  <= 1'b0;
            cfg_smart <= 1'b0;
        end else if (wr_en && aligned && int'(widx) == CFG_W) begin
            cfg_auto  <= wdata[0];
            cfg_smart <= wdata[4];
        end
    end

    // Read multiplexer: select the addressed register, zero when unmapped.
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            if (int'(widx) == ID_W)    rd_mux = DW'(ID_VALUE);
            if (int'(widx) == RSTAT_W) rd_mux = DW'(1);
            if (int'(widx) == CFG_W) begin
                rd_mux[0] = cfg_auto;
                rd_mux[4] = cfg_smart;
            end
            for (int q = 0; q < NUM_Q; q++) begin
                if (int'(widx) == MSG_W + q)  rd_mux = q_head[q];
                if (int'(widx) == FULL_W + q) rd_mux = DW'(q_full[q]);
                if (int'(widx) == CNT_W + q)  rd_mux = DW'(q_cnt[q]);
            end
            for (int u = 0; u < NUM_U; u++) begin
                if (int'(widx) == IRQ_W + 2*u)     rd_mux = DW'(st_all[u]);
                if (int'(widx) == IRQ_W + 2*u + 1) rd_mux = DW'(en_all[u]);
            end
        end
    end

    // Read data register: holds the selected word for one cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_mux : '0;
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Module ipc_mailbox_chk
// Property checker attached to ipc_mailbox. It watches the port strobes
// against queue occupancy, pending bits, masks and interrupt lines.
// Assumes read and write strobes are never high in the same cycle.
module ipc_mailbox_chk #(
    parameter int NUM_Q = 6,
    parameter int NUM_U = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = 12,
    localparam int EW   = 2 * NUM_Q,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [AW-1:0]            addr,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [DW-1:0]            rdata,
    input logic [NUM_U-1:0]         irq,
    input logic [NUM_Q-1:0][CW-1:0] q_cnt,
    input logic [NUM_U-1:0][EW-1:0] st_all,
    input logic [NUM_U-1:0][EW-1:0] en_all
);
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic hit;
        assign hit = (addr[1:0] == 2'b00) && (int'(addr[AW-1:2]) == 16 + q);

        // R2
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[q] <= CW'(DEPTH));

        // R3
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_cnt[q] == CW'(DEPTH) && !(rd_en && hit)) |=> q_cnt[q] == CW'(DEPTH));

        // R4
        empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_cnt[q] == '0 && !(wr_en && hit)) |=> q_cnt[q] == '0);

        // R1
        push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !rd_en && hit && q_cnt[q] < CW'(DEPTH))
                |=> q_cnt[q] == $past(q_cnt[q]) + 1'b1);

        for (genvar u = 0; u < NUM_U; u++) begin : g_u
            // R5
            newmsg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit && q_cnt[q] < CW'(DEPTH)) |=> st_all[u][2*q]);
        end
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_irq
        // R8
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[u] == '0) |-> !irq[u]);
    end

    // R12
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rdata == '0);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .NUM_Q(NUM_Q), .NUM_U(NUM_U), .DEPTH(DEPTH), .DW(DW), .AW(AW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .irq    (irq),
    .q_cnt  (q_cnt),
    .st_all (st_all),
    .en_all (en_all)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
// Bench for ipc_mailbox: sweeps every queue and every mask bit against a
// behavioural model kept in the bench.
module ipc_mailbox_test;
    localparam int NQ = 6;
    localparam int NU = 4;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [31:0] mq   [NQ][DEPTH];
    int          mcnt [NQ];
    logic [11:0] mst  [NU];
    logic [11:0] men  [NU];

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] a_msg(int q);  return 12'(12'h40 + 4*q);  endfunction
    function automatic logic [11:0] a_full(int q); return 12'(12'h80 + 4*q);  endfunction
    function automatic logic [11:0] a_cnt(int q);  return 12'(12'hC0 + 4*q);  endfunction
    function automatic logic [11:0] a_pend(int u); return 12'(12'h100 + 8*u); endfunction
    function automatic logic [11:0] a_mask(int u); return 12'(12'h104 + 8*u); endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Model of a push: accepted only with room, sets new-message bits.
    task automatic push(int q, logic [31:0] d);
        bus_wr(a_msg(q), d);
        if (mcnt[q] < DEPTH) begin
            mq[q][mcnt[q]] = d;
            mcnt[q]++;
            for (int u = 0; u < NU; u++) mst[u][2*q] = 1'b1;
        end
    endtask

    // Model of a pop, with check of the returned word.
    task automatic pop_chk(int q, string tag);
        logic [31:0] got, exp;
        bus_rd(a_msg(q), got);
        exp = '0;
        if (mcnt[q] > 0) begin
            exp = mq[q][0];
            if (mcnt[q] == DEPTH)
                for (int u = 0; u < NU; u++) mst[u][2*q+1] = 1'b1;
            for (int i = 0; i < DEPTH - 1; i++) mq[q][i] = mq[q][i+1];
            mcnt[q]--;
        end
        check(tag, got, exp);
    endtask

    task automatic check_pend(string tag);
        logic [31:0] got;
        for (int u = 0; u < NU; u++) begin
            bus_rd(a_pend(u), got);
            check(tag, got, {20'd0, mst[u]});
        end
    endtask

    task automatic clear_all_pend();
        for (int u = 0; u < NU; u++) begin
            bus_wr(a_pend(u), 32'hFFFF_FFFF);
            mst[u] = '0;
        end
    endtask

    task automatic check_irq(string tag);
        for (int u = 0; u < NU; u++)
            check(tag, {31'd0, irq[u]}, {31'd0, |(mst[u] & men[u])});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        for (int q = 0; q < NQ; q++) mcnt[q] = 0;
        for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check("R9 irq", {28'd0, irq}, 32'd0);
        for (int q = 0; q < NQ; q++) begin
            bus_rd(a_cnt(q), got);  check("R9 count", got, 0);
            bus_rd(a_full(q), got); check("R9 full", got, 0);
        end
        for (int u = 0; u < NU; u++) begin
            bus_rd(a_pend(u), got); check("R9 pending", got, 0);
            bus_rd(a_mask(u), got); check("R9 mask", got, 0);
        end
        bus_rd(12'h014, got); check("R9 reset-status", got, 32'd1);
        bus_rd(12'h010, got); check("R9 config", got, 32'd0);

        // R10: identification and configuration
        bus_rd(12'h000, got); check("R10 id", got, 32'h20);
        bus_wr(12'h010, 32'hFFFF_FFFF); bus_rd(12'h010, got); check("R10 cfg all", got, 32'h11);
        bus_wr(12'h010, 32'h0000_0010); bus_rd(12'h010, got); check("R10 cfg bit4", got, 32'h10);
        bus_wr(12'h010, 32'h0000_0001); bus_rd(12'h010, got); check("R10 cfg bit0", got, 32'h01);

        // R1..R6: fill, overflow, drain, underflow on every queue
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i <= DEPTH; i++) begin
                push(q, 32'hC0DE_0000 + 32'(q * 256 + i));
                bus_rd(a_cnt(q), got);  check("R2 count fill", got, 32'(mcnt[q]));
                bus_rd(a_full(q), got); check("R2 full fill", got, (mcnt[q] == DEPTH) ? 1 : 0);
            end
            check("R3 count held", 32'(mcnt[q]), 32'(DEPTH));
            check_pend("R5 new-message");
            clear_all_pend();
            check_pend("R7 clear all");
            for (int i = 0; i <= DEPTH; i++) begin
                pop_chk(q, (i == DEPTH) ? "R4 empty read" : "R1 order");
                bus_rd(a_cnt(q), got); check("R2 count drain", got, 32'(mcnt[q]));
                check_pend("R6 not-full");
            end
            push(q, 32'h5A5A_0000 + 32'(q));
            pop_chk(q, "R4 pointer kept");
            clear_all_pend();
        end

        // R7: partial clear keeps bits written as zero
        for (int q = 0; q < NQ; q++) push(q, 32'(q));
        check_pend("R5 all queues");
        bus_wr(a_pend(0), 32'h0000_000F); mst[0] = mst[0] & ~12'h00F;
        check_pend("R7 partial clear");
        bus_wr(a_pend(1), 32'h0); check_pend("R7 zero write");

        // R8: every mask bit of every user
        for (int u = 0; u < NU; u++) begin
            for (int b = 0; b < 12; b++) begin
                bus_wr(a_mask(u), 32'h1 << b); men[u] = 12'h1 << b;
                bus_rd(a_mask(u), got); check("R8 mask readback", got, 32'h1 << b);
                check_irq("R8 irq");
            end
            bus_wr(a_mask(u), 32'hFFF); men[u] = 12'hFFF;
            check_irq("R8 irq all");
        end
        clear_all_pend();
        check_irq("R8 irq cleared");

        // R11: unmapped reads and ignored writes
        bus_rd(12'h008, got); check("R11 read 0x008", got, 0);
        bus_rd(12'h03C, got); check("R11 read 0x03C", got, 0);
        bus_rd(12'h058, got); check("R11 read 0x058", got, 0);
        bus_rd(12'h0D8, got); check("R11 read 0x0D8", got, 0);
        bus_rd(12'h120, got); check("R11 read 0x120", got, 0);
        bus_rd(12'h0C1, got); check("R11 read misaligned", got, 0);
        bus_wr(12'h000, 32'h1234_5678);
        bus_wr(12'h014, 32'h0);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_wr(12'h120, 32'hFFFF_FFFF);
        bus_wr(12'h042, 32'hDEAD_BEEF);
        bus_rd(12'h000, got); check("R11 id kept", got, 32'h20);
        bus_rd(12'h014, got); check("R11 reset-status kept", got, 1);
        bus_rd(a_cnt(0), got); check("R11 queue0 count", got, 32'(mcnt[0]));
        bus_rd(a_cnt(1), got); check("R11 queue1 count", got, 32'(mcnt[1]));
        check_pend("R11 pending kept");

        // R12: read data returns to zero after the read cycle
        bus_rd(12'h000, got);
        @(negedge clk); check("R12 idle rdata", rdata, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule